// File: doc/BRIEF.md
# Serial Channel with Diagnostic Loopback

This block is one asynchronous serial channel behind an 8-bit register bus. Software writes a byte into a single transmit holding slot and reads received bytes from a single receive holding slot. Each received byte comes with parity, framing and break flags. A line-format register sets the character shape, and a modem control register drives four active-low handshake outputs. A modem status register reports four active-low handshake inputs and keeps change flags for them. Line timing comes from a 16x baud clock enable supplied from outside the block.

Setting the loopback bit turns the channel into a self-test loop. The transmit shifter output feeds the receiver. The handshake outputs feed the handshake status bits. The TX pin parks at mark and every modem output pin deasserts, so nothing leaves the block. One modem control bit also decides whether the interrupt pin is driven or left floating, and it drives an auxiliary active-low output. All data moves through register reads and writes. There is no streaming handshake and no back-pressure: a write to a full transmit slot replaces the byte waiting there, and a byte that arrives while the receive slot is full is dropped.

Top module: `uart_loop_chan`

## Requirements
- R1: After reset the TX pin is 1, rts_n, dtr_n, out1_n and out2_n are 1, irq_oe is 0, and line status (address 5) reads 0x60.
- R2: Line format at address 3 works as follows. Bits 1:0 give the word length as 5 plus the field value. Bit 2 set gives two stop bits. Bit 3 set enables parity. Bit 4 set selects even parity, and clear selects odd. Data is sent LSB first after a low start bit.
- R3: Modem control (address 4) bit 4 turns loopback on. In loopback a byte written to address 0 comes back, masked to the word length, in the receive slot read at address 0, with no error flags.
- R4: While loopback is on, the TX pin stays at 1 for the whole time and rts_n, dtr_n, out1_n and out2_n stay at 1, whatever modem control bits 3:0 hold.
- R5: In loopback the external cts_n, dsr_n, ri_n and dcd_n are ignored. The modem status bits at address 6 then follow modem control: bit 4 (CTS) takes control bit 1, bit 5 (DSR) takes bit 0, bit 6 (RI) takes bit 2, and bit 7 (DCD) takes bit 3. Outside loopback these status bits show the inverted external pins.
- R6: Modem status change flags work as follows. Bit 0 flags a CTS change, bit 1 a DSR change and bit 3 a DCD change. Bit 2 flags RI going from 1 to 0. All four clear when modem status is read.
- R7: irq_oe equals modem control bit 3. Outside loopback out2_n is the inverse of that bit, and rts_n, dtr_n and out1_n are the inverses of control bits 1, 0 and 2.
- R8: Line status error flags are as follows. Bit 2 flags a parity mismatch. Bit 3 flags a low stop bit. Bit 4 flags a break, which is a line low through the whole character including the stop bit; a break also sets bit 3 and stores 0x00. Reading line status clears bits 1 to 4.
- R9: Line status bit 0 sets when a character is stored and clears when address 0 is read. A character that completes while bit 0 is set is dropped, and it sets overrun flag bit 1.
- R10: Line status bit 5 is 0 from a write to address 0 until the shifter takes the byte. Bit 6 is 1 only when both the holding slot and the shifter are empty.
- R11: Interrupt enable sits at address 1: bit 0 for received data, bit 1 for transmit slot empty, bit 2 for line errors, bit 3 for modem change. irq is 1 when any enabled source is pending. Address 2 then reads 0x06 for line errors, 0x04 for data, 0x02 for slot empty, 0x00 for modem change (in that priority order), and 0x01 when nothing is pending.
- R12: Outside loopback the receiver samples the rx pin, and a byte written to address 0 appears on the TX pin as a start bit, the data bits and a stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud16_en | input | 1 | One-cycle enable at 16 times the bit rate |
| cs | input | 1 | Register select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| tx | output | 1 | Serial output, idles at 1 |
| rx | input | 1 | Serial input |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Terminal-ready, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | Auxiliary output 2, active low |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Set-ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| irq | output | 1 | Interrupt request level |
| irq_oe | output | 1 | Drive enable for the interrupt pin |

## Verification
On every cycle the assertions check several things. A modem control write moves irq_oe and the loopback pin states in the next cycle. A read of the receive slot drops the ready flag. A character that completes on a full slot raises overrun. The transmitter leaves the line at mark when idle and drives a start bit right after it takes a byte. The receiver's bit index stays in range, and a break always also reports a framing error. Some behaviour shows only in the bench's scenarios: whole characters for every word length and parity mode, the exact bit pattern on the TX pin, the modem status remapping in loopback, the priority order of the interrupt identity codes, and error flags caused by malformed frames.

// File: rtl/ulb_pkg.sv
package ulb_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_t;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAIT} rx_state_t;

  typedef struct packed {
    logic       even;
    logic       par_en;
    logic       two_stop;
    logic [1:0] wlen;
  } frame_cfg_t;

  localparam logic [AW-1:0] A_DATA = 3'd0;
  localparam logic [AW-1:0] A_IEN  = 3'd1;
  localparam logic [AW-1:0] A_IID  = 3'd2;
  localparam logic [AW-1:0] A_FMT  = 3'd3;
  localparam logic [AW-1:0] A_MCTL = 3'd4;
  localparam logic [AW-1:0] A_LSTS = 3'd5;
  localparam logic [AW-1:0] A_MSTS = 3'd6;
endpackage

// File: rtl/ulb_tx.sv
module ulb_tx
  import ulb_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  frame_cfg_t    cfg,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  output logic          take,
  output logic          busy,
  output logic          txd
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST_TICK = CW'(OVS - 1);

  tx_state_t     st;
  logic [CW-1:0] tcnt;
  logic [2:0]    bidx;
  logic [DW-1:0] sh;
  logic          par;
  logic          second;

  logic [2:0]    last_bit;
  logic [DW-1:0] masked;
  logic          par_bit;

  always_comb begin
    last_bit = 3'd4 + {1'b0, cfg.wlen};
    masked   = hold_data & (8'hFF >> (2'd3 - cfg.wlen));
    par_bit  = cfg.even ? (^masked) : ~(^masked);
    take     = (st == TX_IDLE) && hold_full;
    busy     = (st != TX_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= TX_IDLE; txd <= 1'b1; tcnt <= '0; bidx <= '0;
      sh <= '0; par <= 1'b0; second <= 1'b0;
    end else if (st == TX_IDLE) begin
      if (hold_full) begin
        st <= TX_START; txd <= 1'b0; sh <= masked; par <= par_bit; tcnt <= '0;
      end
    end else if (tick) begin
      tcnt <= (tcnt == LAST_TICK) ? '0 : tcnt + 1'b1;
      if (tcnt == LAST_TICK) begin
        case (st)
          TX_START: begin st <= TX_DATA; txd <= sh[0]; bidx <= '0; end
          TX_DATA: begin
            if (bidx == last_bit) begin
              if (cfg.par_en) begin st <= TX_PAR; txd <= par; end
              else begin st <= TX_STOP; txd <= 1'b1; second <= 1'b0; end
            end else begin
              bidx <= bidx + 1'b1; sh <= sh >> 1; txd <= sh[1];
            end
          end
          TX_PAR: begin st <= TX_STOP; txd <= 1'b1; second <= 1'b0; end
          TX_STOP: begin
            if (cfg.two_stop && !second) second <= 1'b1;
            else st <= TX_IDLE;
          end
          default: st <= TX_IDLE;
        endcase
      end
    end
  end

  // R12
  idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (st == TX_IDLE) |-> txd);
  // R12
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !txd);
endmodule

// File: rtl/ulb_rx.sv
module ulb_rx
  import ulb_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [1:0]    wlen,
  input  logic          par_en,
  input  logic          even,
  input  logic          rxd,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          perr,
  output logic          ferr,
  output logic          brk
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST_TICK = CW'(OVS - 1);
  localparam logic [CW-1:0] MID_TICK  = CW'(OVS / 2 - 1);

  rx_state_t     st;
  logic [CW-1:0] tcnt;
  logic [2:0]    bidx;
  logic          pbit;
  logic          all_low;
  logic [2:0]    last_bit;
  logic          exp_par;

  always_comb begin
    last_bit = 3'd4 + {1'b0, wlen};
    exp_par  = even ? (^data) : ~(^data);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= RX_IDLE; tcnt <= '0; bidx <= '0; data <= '0; pbit <= 1'b0;
      all_low <= 1'b0; done <= 1'b0; perr <= 1'b0; ferr <= 1'b0; brk <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        RX_IDLE: if (!rxd) begin st <= RX_START; tcnt <= '0; end
        RX_START: if (tick) begin
          if (tcnt == MID_TICK) begin
            tcnt <= '0;
            if (!rxd) begin st <= RX_DATA; bidx <= '0; data <= '0; all_low <= 1'b1; end
            else st <= RX_IDLE;
          end else tcnt <= tcnt + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (tcnt == LAST_TICK) begin
            tcnt <= '0;
            data[bidx] <= rxd;
            if (rxd) all_low <= 1'b0;
            if (bidx == last_bit) st <= par_en ? RX_PAR : RX_STOP;
            else bidx <= bidx + 1'b1;
          end else tcnt <= tcnt + 1'b1;
        end
        RX_PAR: if (tick) begin
          if (tcnt == LAST_TICK) begin
            tcnt <= '0; pbit <= rxd; st <= RX_STOP;
            if (rxd) all_low <= 1'b0;
          end else tcnt <= tcnt + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (tcnt == LAST_TICK) begin
            tcnt <= '0;
            done <= 1'b1;
            ferr <= !rxd;
            brk  <= !rxd && all_low;
            perr <= par_en && (pbit != exp_par);
            st   <= rxd ? RX_IDLE : RX_WAIT;
          end else tcnt <= tcnt + 1'b1;
        end
        RX_WAIT: if (rxd) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end

  // R2
  bit_range_chk: assert property (@(posedge clk) disable iff (rst)
    (st == RX_DATA) |-> (bidx <= last_bit));
  // R8
  break_frames_chk: assert property (@(posedge clk) disable iff (rst)
    (done && brk) |-> ferr);
endmodule

// File: rtl/ulb_modem.sv
module ulb_modem (
  input  logic       clk,
  input  logic       rst,
  input  logic       loop,
  input  logic [3:0] mctl,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  input  logic       rd_clr,
  output logic [7:0] msts
);
  // vectors ordered {dcd, ri, dsr, cts}, active high
  logic [3:0] s1, s2, live, prev, dlt, evt;

  always_comb begin
    live = loop ? {mctl[3], mctl[2], mctl[0], mctl[1]} : s2;
    evt  = {prev[3] ^ live[3], prev[2] & ~live[2], prev[1] ^ live[1], prev[0] ^ live[0]};
    msts = {prev, dlt};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0; s2 <= '0; prev <= '0; dlt <= '0;
    end else begin
      s1   <= {~dcd_n, ~ri_n, ~dsr_n, ~cts_n};
      s2   <= s1;
      prev <= live;
      dlt  <= (rd_clr ? 4'b0 : dlt) | evt;
    end
  end

  // R6
  delta_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && evt == 4'b0) |=> (msts[3:0] == 4'b0));
endmodule

// File: rtl/uart_loop_chan.sv
module uart_loop_chan
  import ulb_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud16_en,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          tx,
  input  logic          rx,
  output logic          rts_n,
  output logic          dtr_n,
  output logic          out1_n,
  output logic          out2_n,
  input  logic          cts_n,
  input  logic          dsr_n,
  input  logic          ri_n,
  input  logic          dcd_n,
  output logic          irq,
  output logic          irq_oe
);
  logic [DW-1:0] thr, rhr, fmt;
  logic          thr_full, dr, oe, pe, fe, bi;
  logic [3:0]    ien;
  logic [4:0]    mctl;
  logic          loop;
  logic          take, tx_busy, txd;
  logic          rx_s1, rx_s2, rx_src;
  logic          rx_done, rx_perr, rx_ferr, rx_brk;
  logic [DW-1:0] rx_data;
  logic [7:0]    msts, lsts, iid;
  frame_cfg_t    cfg;
  logic          wr_hit, rd_hit;
  logic          p_line, p_data, p_empty, p_modem;

  assign loop   = mctl[4];
  assign cfg    = frame_cfg_t'(fmt[4:0]);
  assign wr_hit = cs && wr;
  assign rd_hit = cs && rd;
  assign rx_src = loop ? txd : rx;

  ulb_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(baud16_en), .cfg(cfg),
    .hold_full(thr_full), .hold_data(thr), .take(take), .busy(tx_busy), .txd(txd)
  );

  ulb_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(baud16_en), .wlen(cfg.wlen), .par_en(cfg.par_en),
    .even(cfg.even), .rxd(rx_s2), .done(rx_done), .data(rx_data),
    .perr(rx_perr), .ferr(rx_ferr), .brk(rx_brk)
  );

  ulb_modem u_modem (
    .clk(clk), .rst(rst), .loop(loop), .mctl(mctl[3:0]),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .rd_clr(rd_hit && addr == A_MSTS), .msts(msts)
  );

  always_comb begin
    lsts    = {1'b0, ~thr_full & ~tx_busy, ~thr_full, bi, fe, pe, oe, dr};
    p_line  = ien[2] && (oe || pe || fe || bi);
    p_data  = ien[0] && dr;
    p_empty = ien[1] && !thr_full;
    p_modem = ien[3] && (msts[3:0] != 4'b0);
    if (p_line)       iid = 8'h06;
    else if (p_data)  iid = 8'h04;
    else if (p_empty) iid = 8'h02;
    else if (p_modem) iid = 8'h00;
    else              iid = 8'h01;
    irq    = p_line || p_data || p_empty || p_modem;
    irq_oe = mctl[3];
    tx     = loop ? 1'b1 : txd;
    dtr_n  = loop ? 1'b1 : ~mctl[0];
    rts_n  = loop ? 1'b1 : ~mctl[1];
    out1_n = loop ? 1'b1 : ~mctl[2];
    out2_n = loop ? 1'b1 : ~mctl[3];
    case (addr)
      A_DATA:  rdata = rhr;
      A_IEN:   rdata = {4'b0, ien};
      A_IID:   rdata = iid;
      A_FMT:   rdata = fmt;
      A_MCTL:  rdata = {3'b0, mctl};
      A_LSTS:  rdata = lsts;
      A_MSTS:  rdata = msts;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_s1 <= 1'b1; rx_s2 <= 1'b1;
      thr <= '0; thr_full <= 1'b0; rhr <= '0; fmt <= '0; ien <= '0; mctl <= '0;
      dr <= 1'b0; oe <= 1'b0; pe <= 1'b0; fe <= 1'b0; bi <= 1'b0;
    end else begin
      rx_s1 <= rx_src;
      rx_s2 <= rx_s1;
      if (take) thr_full <= 1'b0;
      if (wr_hit) begin
        case (addr)
          A_DATA: begin thr <= wdata; thr_full <= 1'b1; end
          A_IEN:  ien  <= wdata[3:0];
          A_FMT:  fmt  <= wdata;
          A_MCTL: mctl <= wdata[4:0];
          default: ;
        endcase
      end
      if (rd_hit && addr == A_DATA) dr <= 1'b0;
      if (rd_hit && addr == A_LSTS) begin oe <= 1'b0; pe <= 1'b0; fe <= 1'b0; bi <= 1'b0; end
      if (rx_done) begin
        if (dr && !(rd_hit && addr == A_DATA)) oe <= 1'b1;
        else begin
          rhr <= rx_data; dr <= 1'b1;
          pe <= rx_perr; fe <= rx_ferr; bi <= rx_brk;
        end
      end
    end
  end

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && addr == A_MCTL) |=> (irq_oe == $past(wdata[3])));
  // R4
  loop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && addr == A_MCTL && wdata[4]) |=> (tx && rts_n && dtr_n && out1_n && out2_n));
  // R9
  ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && addr == A_DATA && !rx_done) |=> !dr);
  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done && dr && !rd_hit) |=> oe);
endmodule

// File: tb/tb_uart_loop_chan.sv
module tb_uart_loop_chan;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 0, rd = 0, wr = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic tx, rts_n, dtr_n, out1_n, out2_n, irq, irq_oe;
  logic rx_drv = 1'b1;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  int checks = 0, failures = 0, tx_bad = 0;
  bit mon_loop = 0, finished = 0;

  always #10 clk = ~clk;

  uart_loop_chan dut (
    .clk(clk), .rst(rst), .baud16_en(1'b1), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx(tx), .rx(rx_drv), .rts_n(rts_n), .dtr_n(dtr_n),
    .out1_n(out1_n), .out2_n(out2_n), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
    .dcd_n(dcd_n), .irq(irq), .irq_oe(irq_oe)
  );

  always @(negedge clk) if (mon_loop && (tx !== 1'b1 || rts_n !== 1'b1 || dtr_n !== 1'b1
                                          || out1_n !== 1'b1 || out2_n !== 1'b1)) tx_bad++;

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #2 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    bus_rd(a, v);
    check(v === exp, tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nd, input bit use_par,
                            input bit pbit, input bit stopv);
    rx_drv = 0; idle(16);
    for (int i = 0; i < nd; i++) begin rx_drv = d[i]; idle(16); end
    if (use_par) begin rx_drv = pbit; idle(16); end
    rx_drv = stopv; idle(16);
    rx_drv = 1; idle(20);
  endtask

  task automatic t_reset;
    check({tx, rts_n, dtr_n, out1_n, out2_n} === 5'b11111, "R1 pins", {3'b0, tx, rts_n, dtr_n, out1_n, out2_n}, 8'h1F);
    check(irq_oe === 1'b0, "R1 irq_oe", {7'b0, irq_oe}, 8'h00);
    expect_reg(3'd5, 8'h60, "R1 line status");
  endtask

  task automatic t_loop_formats;
    logic [7:0] d, m;
    bus_wr(3'd4, 8'h1F);
    idle(2);
    mon_loop = 1;
    for (int w = 0; w < 4; w++) begin
      for (int p = 0; p < 3; p++) begin
        d = 8'hA5 ^ 8'(w * 37 + p * 91);
        m = d & (8'hFF >> (3 - w));
        bus_wr(3'd3, 8'(w) | 8'((w + p) % 2) << 2 | (p != 0 ? 8'h08 : 8'h00) | (p == 2 ? 8'h10 : 8'h00));
        bus_wr(3'd0, d);
        idle(260);
        expect_reg(3'd5, 8'h61, "R2 R3 loop status");
        expect_reg(3'd0, m, "R2 R3 loop data");
      end
    end
    mon_loop = 0;
    check(tx_bad == 0, "R4 pins quiet in loopback", 8'(tx_bad), 8'h00);
  endtask

  task automatic t_loop_modem;
    logic [7:0] v;
    bus_wr(3'd4, 8'h10); idle(3);
    bus_rd(3'd6, v);
    cts_n = 0; dsr_n = 0; ri_n = 0; dcd_n = 0; idle(5);
    expect_reg(3'd6, 8'h00, "R5 external ignored");
    bus_wr(3'd4, 8'h12); idle(3);
    expect_reg(3'd6, 8'h11, "R5 R6 rts to cts");
    expect_reg(3'd6, 8'h10, "R6 delta cleared");
    bus_wr(3'd4, 8'h1F); idle(3);
    expect_reg(3'd6, 8'hFA, "R5 R6 all raised");
    bus_wr(3'd4, 8'h1B); idle(3);
    expect_reg(3'd6, 8'hB4, "R6 ring trailing edge");
    bus_wr(3'd4, 8'h00); idle(5);
    expect_reg(3'd6, 8'hF0, "R5 external after loopback");
    cts_n = 1; dsr_n = 1; ri_n = 1; dcd_n = 1; idle(5);
    bus_rd(3'd6, v);
  endtask

  task automatic t_irq_gate;
    bus_wr(3'd4, 8'h08); idle(1);
    check(irq_oe === 1 && out2_n === 0, "R7 bit3 set", {6'b0, irq_oe, out2_n}, 8'h02);
    bus_wr(3'd4, 8'h07); idle(1);
    check(irq_oe === 0 && {out2_n, out1_n, rts_n, dtr_n} === 4'b1000, "R7 bits",
          {3'b0, irq_oe, out2_n, out1_n, rts_n, dtr_n}, 8'h08);
    bus_wr(3'd4, 8'h00); idle(1);
    check(irq_oe === 0 && out2_n === 1, "R7 bit3 clear", {6'b0, irq_oe, out2_n}, 8'h01);
  endtask

  task automatic t_ext_rx;
    bus_wr(3'd3, 8'h1B);
    send_frame(8'h3C, 8, 1, 0, 1);
    expect_reg(3'd5, 8'h61, "R12 good frame status");
    expect_reg(3'd0, 8'h3C, "R12 good frame data");
    send_frame(8'h3C, 8, 1, 1, 1);
    expect_reg(3'd5, 8'h65, "R8 parity error");
    expect_reg(3'd0, 8'h3C, "R8 parity data");
    send_frame(8'h3C, 8, 1, 0, 0);
    expect_reg(3'd5, 8'h69, "R8 framing error");
    expect_reg(3'd0, 8'h3C, "R8 framing data");
    bus_wr(3'd3, 8'h03);
    rx_drv = 0; idle(12 * 16); rx_drv = 1; idle(30);
    expect_reg(3'd5, 8'h79, "R8 break");
    expect_reg(3'd0, 8'h00, "R8 break data");
    expect_reg(3'd5, 8'h60, "R8 errors cleared by read");
  endtask

  task automatic t_overrun;
    bus_wr(3'd4, 8'h10); bus_wr(3'd3, 8'h03);
    bus_wr(3'd0, 8'h5A); idle(260);
    bus_wr(3'd0, 8'hC3); idle(260);
    expect_reg(3'd5, 8'h63, "R9 overrun status");
    expect_reg(3'd0, 8'h5A, "R9 first byte kept");
    expect_reg(3'd5, 8'h60, "R9 ready cleared");
    bus_wr(3'd4, 8'h00); idle(4);
  endtask

  task automatic t_thre;
    bus_wr(3'd3, 8'h03);
    bus_wr(3'd0, 8'h55);
    expect_reg(3'd5, 8'h20, "R10 shifter busy");
    bus_wr(3'd0, 8'h0F);
    expect_reg(3'd5, 8'h00, "R10 slot full");
    idle(400);
    expect_reg(3'd5, 8'h60, "R10 all empty");
  endtask

  task automatic t_tx_frame;
    logic [7:0] got;
    logic st, sp;
    int guard;
    bus_wr(3'd3, 8'h03);
    bus_wr(3'd0, 8'hA5);
    guard = 0;
    while (tx === 1'b1 && guard < 50) begin @(negedge clk); guard++; end
    idle(8); st = tx;
    for (int i = 0; i < 8; i++) begin idle(16); got[i] = tx; end
    idle(16); sp = tx;
    check(st === 0 && sp === 1 && got === 8'hA5, "R12 tx frame", got, 8'hA5);
    idle(30);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    bus_wr(3'd4, 8'h18); bus_wr(3'd3, 8'h03); idle(3);
    bus_rd(3'd6, v); bus_rd(3'd5, v); bus_rd(3'd0, v);
    bus_wr(3'd1, 8'h02); idle(1);
    check(irq === 1, "R11 empty irq", {7'b0, irq}, 8'h01);
    expect_reg(3'd2, 8'h02, "R11 empty id");
    bus_wr(3'd1, 8'h01); idle(1);
    check(irq === 0, "R11 no irq", {7'b0, irq}, 8'h00);
    expect_reg(3'd2, 8'h01, "R11 none id");
    bus_wr(3'd0, 8'h11); idle(260);
    expect_reg(3'd2, 8'h04, "R11 data id");
    bus_wr(3'd1, 8'h05);
    bus_wr(3'd0, 8'h22); idle(260);
    expect_reg(3'd2, 8'h06, "R11 line id priority");
    bus_rd(3'd5, v);
    expect_reg(3'd2, 8'h04, "R11 data after line clear");
    bus_rd(3'd0, v); idle(1);
    check(irq === 0, "R11 irq dropped", {7'b0, irq}, 8'h00);
    bus_wr(3'd1, 8'h00); bus_wr(3'd4, 8'h00); idle(4);
  endtask

  initial begin
    idle(4); rst = 0; idle(2);
    t_reset();
    t_loop_formats();
    t_loop_modem();
    t_irq_gate();
    t_ext_rx();
    t_overrun();
    t_thre();
    t_tx_frame();
    t_irq();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule